// File: doc/BRIEF.md
# Indirect-Pointer Single-Channel DMA Engine

This block is one DMA channel placed inside a peripheral. On each granted request it moves a single byte between the peripheral's data register and a target. The target is either the shared register file or a byte-addressed memory. The channel keeps no address or byte count of its own. It holds only a base index into the register file. Through that index it fetches the pointer and the counter, performs the move, and writes the advanced pointer and the reduced counter back to the same locations.

Software sets up the pointer and counter locations in the register file. It then pulses `arm` with the base index, the target select and the direction. From that point every `req` pulse seen while the channel is idle starts one transfer. When a writeback leaves the counter at zero, the channel raises a one-cycle end-of-block pulse and disarms itself. It accepts no further request until it is armed again.

Top module: `dma_ind_channel`

## Requirements
- R1: After reset the channel is idle and disarmed: `busy`, `eob`, `rf_we`, `mem_valid` and `pd_wr` are low, and a `req` has no effect until `arm` has been pulsed.
- R2: A pulse on `arm` while idle latches `cfg_base`, `cfg_mem` and `cfg_dir` and arms the channel. When `arm` and `req` are both high in the same idle cycle, the arm is taken and the request is dropped, so no transfer starts.
- R3: Register-file target (`cfg_mem`=0): the pointer is at `base` and the counter at `base+1`. A transfer reads the pointer, then the counter, then moves one byte at register address `pointer`. It then writes `pointer+1` (modulo 256) to `base` and `counter-1` (modulo 256) to `base+1`, in that order.
- R4: Memory target (`cfg_mem`=1): `base`..`base+3` hold the pointer high byte, pointer low byte, counter high byte and counter low byte. They are read in that order, and the 16-bit `pointer+1` and `counter-1` are written back in the same order, with carry and borrow across the byte boundary.
- R5: With `cfg_dir`=0 the byte on `pd_rdata` is written to the target at the pointer. With `cfg_dir`=1 the target byte at the pointer is delivered on `pd_wdata` with a one-cycle `pd_wr` strobe. A memory access never asserts `rf_we` in the same cycle.
- R6: A memory access raises `mem_valid` with `mem_addr`, `mem_we` and `mem_wdata` held steady until `mem_ready` is seen. The channel stalls until then.
- R7: When the written-back counter is zero, `eob` is high for exactly one cycle: the first idle cycle after the last writeback. The channel is then disarmed, and later requests are ignored until it is armed again.
- R8: In memory mode a counter of 0 stands for 65536 bytes. Such a transfer writes back 0xFFFF and raises no `eob`.
- R9: An `arm` pulse in the same cycle as `eob` re-arms the channel, and the next request is served.
- R10: `busy` is high from the cycle after an accepted request through the last writeback. Requests while busy are ignored, and the register-file and memory ports are quiet while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| arm | input | 1 | latch configuration and arm the channel |
| cfg_mem | input | 1 | target select: 0 register file, 1 memory |
| cfg_dir | input | 1 | 0 peripheral to target, 1 target to peripheral |
| cfg_base | input | RF_AW | register-file index of the pointer/counter block |
| req | input | 1 | granted transfer request |
| busy | output | 1 | transfer in progress |
| eob | output | 1 | one-cycle end-of-block pulse |
| rf_addr | output | RF_AW | register-file address |
| rf_we | output | 1 | register-file write enable |
| rf_wdata | output | DW | register-file write data |
| rf_rdata | input | DW | register-file read data (combinational) |
| mem_valid | output | 1 | memory access request |
| mem_we | output | 1 | memory write (1) or read (0) |
| mem_addr | output | 2*DW | memory byte address |
| mem_wdata | output | DW | memory write data |
| mem_rdata | input | DW | memory read data, valid with ready |
| mem_ready | input | 1 | memory access complete |
| pd_rdata | input | DW | peripheral data register contents |
| pd_wr | output | 1 | load strobe for the peripheral data register |
| pd_wdata | output | DW | data for the peripheral data register |

## Verification
Re-arming and end-of-block can fall in the same cycle. The bench provokes this by driving `arm` in exactly the idle cycle where `eob` is sampled high. It judges the result by checking that a following request is served and that its writebacks match the model. A request and an arm can also coincide. The bench drives both in one idle cycle and expects no transfer: `busy` stays low and no port event reaches the scoreboard. After that it expects the next request alone to start a normal transfer.

// File: rtl/dma_ind_channel.sv
module dma_ind_channel #(
  parameter int DW    = 8,
  parameter int RF_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cfg_mem,
  input  logic             cfg_dir,
  input  logic [RF_AW-1:0] cfg_base,
  input  logic             req,
  output logic             busy,
  output logic             eob,
  output logic [RF_AW-1:0] rf_addr,
  output logic             rf_we,
  output logic [DW-1:0]    rf_wdata,
  input  logic [DW-1:0]    rf_rdata,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [2*DW-1:0]  mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    pd_rdata,
  output logic             pd_wr,
  output logic [DW-1:0]    pd_wdata
);
  localparam int PW = 2 * DW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_XF, S_WB} st_t;

  st_t             st;
  logic [1:0]      step;
  logic            en, mode_q, dir_q;
  logic [RF_AW-1:0] base_q;
  logic [PW-1:0]   ptr, cnt;

  wire [1:0]    slot  = mode_q ? step : {step[0], 1'b1};
  wire          last  = (step == (mode_q ? 2'd3 : 2'd1));
  wire [PW-1:0] nptr  = ptr + 1'b1;
  wire [PW-1:0] ncnt  = cnt - 1'b1;
  wire          nzero = mode_q ? (ncnt == '0) : (ncnt[DW-1:0] == '0);
  wire          xf_ok = !mode_q || mem_ready;

  logic [DW-1:0] wb_byte;
  always_comb begin
    case (slot)
      2'd0:    wb_byte = nptr[PW-1:DW];
      2'd1:    wb_byte = nptr[DW-1:0];
      2'd2:    wb_byte = ncnt[PW-1:DW];
      default: wb_byte = ncnt[DW-1:0];
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign rf_addr   = (st == S_XF) ? ptr[RF_AW-1:0] : base_q + RF_AW'(step);
  assign rf_we     = (st == S_WB) || (st == S_XF && !mode_q && !dir_q);
  assign rf_wdata  = (st == S_XF) ? pd_rdata : wb_byte;
  assign mem_valid = (st == S_XF) && mode_q;
  assign mem_we    = !dir_q;
  assign mem_addr  = ptr;
  assign mem_wdata = pd_rdata;
  assign pd_wr     = (st == S_XF) && dir_q && xf_ok;
  assign pd_wdata  = mode_q ? mem_rdata : rf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      en     <= 1'b0;
      mode_q <= 1'b0;
      dir_q  <= 1'b0;
      base_q <= '0;
      ptr    <= '0;
      cnt    <= '0;
      eob    <= 1'b0;
    end else begin
      eob <= 1'b0;
      case (st)
        S_IDLE: begin
          if (arm) begin
            en     <= 1'b1;
            base_q <= cfg_base;
            mode_q <= cfg_mem;
            dir_q  <= cfg_dir;
          end else if (req && en) begin
            st   <= S_RD;
            step <= '0;
            ptr  <= '0;
            cnt  <= '0;
          end
        end
        S_RD: begin
          case (slot)
            2'd0:    ptr[PW-1:DW] <= rf_rdata;
            2'd1:    ptr[DW-1:0]  <= rf_rdata;
            2'd2:    cnt[PW-1:DW] <= rf_rdata;
            default: cnt[DW-1:0]  <= rf_rdata;
          endcase
          if (last) begin
            st   <= S_XF;
            step <= '0;
          end else begin
            step <= step + 2'd1;
          end
        end
        S_XF: if (xf_ok) st <= S_WB;
        default: begin
          if (last) begin
            st   <= S_IDLE;
            step <= '0;
            if (nzero) begin
              eob <= 1'b1;
              en  <= 1'b0;
            end
          end else begin
            step <= step + 2'd1;
          end
        end
      endcase
    end
  end
endmodule

module dma_ind_channel_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          eob,
  input logic          rf_we,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          pd_wr
);
  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  a_r7_eob_single: assert property (@(posedge clk) disable iff (!rst_n)
    eob |=> !eob);

  a_r7_eob_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    eob |-> $past(rf_we) && !busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rf_we && !mem_valid && !pd_wr);

  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !rf_we);
endmodule

bind dma_ind_channel dma_ind_channel_chk #(.AW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eob(eob), .rf_we(rf_we),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .pd_wr(pd_wr)
);

// File: tb/sim_dma_ind_channel.sv
module sim_dma_ind_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic arm = 0, cfg_mem = 0, cfg_dir = 0, req = 0;
  logic [7:0] cfg_base = 0;
  logic busy, eob, rf_we, mem_valid, mem_we, mem_ready, pd_wr;
  logic [7:0] rf_addr, rf_wdata, rf_rdata, mem_wdata, mem_rdata, pd_wdata;
  logic [7:0] pd_rdata = 0;
  logic [15:0] mem_addr;

  dma_ind_channel u0 (.*);

  logic [7:0] rf [256];
  assign rf_rdata = rf[rf_addr];
  always @(posedge clk) if (rf_we) rf[rf_addr] <= rf_wdata;

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  int lat = 0;
  logic [3:0] wcnt = 0;
  assign mem_ready = mem_valid && (int'(wcnt) >= lat);
  assign mem_rdata = mf(mem_addr);
  always @(posedge clk) wcnt <= (mem_valid && !mem_ready) ? wcnt + 4'd1 : 4'd0;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  logic [25:0] exp_q[$];

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // monitor: kind 0 = rf write, 1 = memory write, 2 = peripheral load
  always @(negedge clk) if (rst_n) begin
    logic [25:0] got;
    bit ev;
    ev = 1'b1;
    if (rf_we) got = {2'd0, 8'h00, rf_addr, rf_wdata};
    else if (mem_valid && mem_ready && mem_we) got = {2'd1, mem_addr, mem_wdata};
    else if (pd_wr) got = {2'd2, 16'h0, pd_wdata};
    else ev = 1'b0;
    if (ev) begin
      if (exp_q.size() == 0) chk(0, {tag, " unexpected event"}, int'(got), 0);
      else begin
        logic [25:0] e;
        e = exp_q.pop_front();
        chk(got == e, {tag, " event"}, int'(got), int'(e));
      end
    end
  end

  task automatic arm_ch(input logic [7:0] b, input bit m, input bit d, input bit with_req);
    @(negedge clk);
    cfg_base = b; cfg_mem = m; cfg_dir = d; arm = 1; req = with_req;
    @(negedge clk);
    arm = 0; req = 0;
  endtask

  task automatic xfer(input string t, input bit extra, input bit arm_end);
    logic [15:0] p, c, np, nc;
    logic [7:0] b;
    bit ez;
    tag = t;
    b = cfg_base;
    if (!cfg_mem) begin
      p = {8'h0, rf[b]}; c = {8'h0, rf[b+8'd1]};
      np = {8'h0, p[7:0] + 8'd1}; nc = {8'h0, c[7:0] - 8'd1};
      if (cfg_dir) exp_q.push_back({2'd2, 16'h0, rf[p[7:0]]});
      else exp_q.push_back({2'd0, 8'h0, p[7:0], pd_rdata});
      exp_q.push_back({2'd0, 8'h0, b, np[7:0]});
      exp_q.push_back({2'd0, 8'h0, b + 8'd1, nc[7:0]});
      ez = (nc[7:0] == 0);
    end else begin
      p = {rf[b], rf[b+8'd1]}; c = {rf[b+8'd2], rf[b+8'd3]};
      np = p + 16'd1; nc = c - 16'd1;
      if (cfg_dir) exp_q.push_back({2'd2, 16'h0, mf(p)});
      else exp_q.push_back({2'd1, p, pd_rdata});
      exp_q.push_back({2'd0, 8'h0, b, np[15:8]});
      exp_q.push_back({2'd0, 8'h0, b + 8'd1, np[7:0]});
      exp_q.push_back({2'd0, 8'h0, b + 8'd2, nc[15:8]});
      exp_q.push_back({2'd0, 8'h0, b + 8'd3, nc[7:0]});
      ez = (nc == 0);
    end
    req = 1;
    @(negedge clk);
    if (!extra) req = 0;
    chk(busy, {t, " R10 busy after accept"}, busy, 1);
    if (extra) begin
      @(negedge clk); @(negedge clk);
      req = 0;
    end
    while (busy) @(negedge clk);
    chk(eob == ez, {t, " R7 eob"}, eob, ez);
    if (arm_end) begin
      arm = 1;
      @(negedge clk);
      arm = 0;
    end
    @(negedge clk);
    chk(!busy && !eob, {t, " R10 idle after"}, busy, 0);
    chk(exp_q.size() == 0, {t, " all events seen"}, exp_q.size(), 0);
  endtask

  task automatic ignored(input string t);
    tag = t;
    req = 1;
    @(negedge clk);
    req = 0;
    chk(!busy, {t, " request ignored"}, busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy, {t, " still idle"}, busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!busy && !eob && !rf_we && !mem_valid && !pd_wr, "R1 reset outputs", busy, 0);
    rst_n = 1;
    @(negedge clk);
    ignored("R1 before arm");

    // register-file target, peripheral to target
    rf[8'h10] = 8'h40; rf[8'h11] = 8'd3;
    arm_ch(8'h10, 0, 0, 0);
    pd_rdata = 8'hA1; xfer("R3 R5 rf p2t #1", 0, 0);
    pd_rdata = 8'hB2; xfer("R3 R5 rf p2t #2", 0, 0);
    pd_rdata = 8'hC3; xfer("R3 R7 rf p2t last", 0, 0);
    chk(rf[8'h40] == 8'hA1 && rf[8'h42] == 8'hC3, "R3 rf data stored", rf[8'h42], 8'hC3);
    ignored("R7 after eob");

    // register-file target, target to peripheral, re-arm in the eob cycle
    rf[8'h20] = 8'h80; rf[8'h21] = 8'd2;
    arm_ch(8'h20, 0, 1, 0);
    xfer("R5 rf t2p #1", 0, 0);
    xfer("R9 rf t2p last with arm", 0, 1);
    rf[8'h21] = 8'd1;
    xfer("R9 served after rearm", 0, 0);

    // memory target, carry and borrow, handshake
    rf[8'h30] = 8'h12; rf[8'h31] = 8'hFF; rf[8'h32] = 8'h01; rf[8'h33] = 8'h00;
    arm_ch(8'h30, 1, 0, 0);
    lat = 0; pd_rdata = 8'h3C; xfer("R4 mem p2t carry", 0, 0);
    chk({rf[8'h30], rf[8'h31]} == 16'h1300, "R4 pointer carry", {rf[8'h30], rf[8'h31]}, 16'h1300);
    lat = 3; pd_rdata = 8'h4D; xfer("R6 R10 mem p2t stall", 1, 0);
    arm_ch(8'h30, 1, 1, 0);
    lat = 2; xfer("R5 R6 mem t2p", 0, 0);

    // zero count means 65536
    rf[8'h32] = 8'h00; rf[8'h33] = 8'h00;
    lat = 1; pd_rdata = 8'h77; xfer("R8 mem count zero", 0, 0);
    chk({rf[8'h32], rf[8'h33]} == 16'hFFFF, "R8 count wraps", {rf[8'h32], rf[8'h33]}, 16'hFFFF);
    rf[8'h32] = 8'h00; rf[8'h33] = 8'h01;
    xfer("R7 mem last byte", 0, 0);
    ignored("R7 mem after eob");

    // arm and request in the same cycle
    tag = "R2 arm+req";
    rf[8'h50] = 8'h90; rf[8'h51] = 8'd5;
    arm_ch(8'h50, 0, 0, 1);
    chk(!busy, "R2 request dropped on arm", busy, 0);
    repeat (2) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R2 no transfer", busy, 0);
    pd_rdata = 8'h5E; xfer("R2 next request served", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule